// File: doc/BRIEF.md
# Gated Clock Frequency Meter

The block estimates the frequency of a free-running on-chip oscillator. It counts cycles of the known reference clock while a programmed number of rising edges of the measured clock go by. The two counts together give the ratio of the two frequencies. Software selects the window length (a 24-bit count of measured edges), sets a free-run gate that lets the oscillator into the meter, and then turns the meter on. When the window is complete, software sees a sticky completion flag and reads the reference-cycle count.

The measured clock enters through a synchronizer of configurable depth, followed by a rising-edge detector. The window counter and the reference counter therefore both run in the reference domain. The reference counter saturates instead of wrapping. The result register reads zero until the completion flag is set, so a dead oscillator shows as a zero result. Turning the meter off clears the flag and both counters at once, ready for a new window.

Top module: `freq_meter`

## Requirements
- R1: After reset, the control register (offset 0x00), the monitor register (offset 0x10) and the result register (offset 0x0c) all read zero, and `frck_en_o` is low.
- R2: The control register holds the window target in bits 23:0 and the meter enable in bit 24. Both read back as written. Bits 31:25 read zero.
- R3: Monitor bit 8 is the free-run gate. It is read/write and drives `frck_en_o`. Monitor bit 0 is the completion flag, which software can only read. All other monitor bits read zero.
- R4: While the enable and the gate are both set, the completion flag rises once the number of measured rising edges reaches the target. It then stays set while the enable stays set.
- R5: For a measured clock with a steady period of P reference cycles and a target T ≥ 1, the result lies between (T-1)·P+1 and T·P inclusive.
- R6: The result register reads zero while the completion flag is low, including when the measured clock never toggles.
- R7: The reference counter saturates at all ones of its width (parameter `CNT_W`) and does not wrap.
- R8: A control write that clears the enable clears the completion flag and both counters at that write's clock edge. The following enable starts a fresh window.
- R9: While the free-run gate is clear, measured edges are not counted, the reference counter holds, and the completion flag does not rise. Setting the gate again resumes the window.
- R10: Writes to the result register or to monitor bit 0 have no effect. Reads of unmapped offsets return zero.
- R11: A target of zero completes after one reference cycle of running, with a result of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 8 | Register byte offset for read and write |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| meas_clk_i | input | 1 | Measured clock, from the oscillator |
| frck_en_o | output | 1 | Free-run gate for the oscillator |

## Verification
The assertions assume that register writes arrive as single-cycle strobes with stable address and data. They also assume that the measured input, once passed through the free-run gate, is a level signal with no glitches inside a reference cycle. The bench drives the measured clock away from the reference edge, using a phase counter with a period of at least two cycles. It changes that period only while the oscillator is stopped, and it starts each timed window only after the oscillator has run for a while. Under these conditions every edge reaches the window counter, and the R5 bounds are exact.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int unsigned REG_AW    = 8;
  localparam int unsigned REG_DW    = 32;
  localparam int unsigned TGT_W     = 24;
  localparam int unsigned EN_BIT    = 24;
  localparam int unsigned FRCK_BIT  = 8;
  localparam int unsigned VALID_BIT = 0;

  localparam logic [REG_AW-1:0] OFS_CTRL = 8'h00;
  localparam logic [REG_AW-1:0] OFS_RES  = 8'h0c;
  localparam logic [REG_AW-1:0] OFS_MON  = 8'h10;
endpackage

// File: rtl/fm_sync_edge.sv
module fm_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] & ~prev_q;

  // each edge is a single-cycle pulse feeding the window counter
  assert_edge_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/fm_window.sv
module fm_window #(
  parameter int unsigned TGT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             edge_i,
  input  logic [TGT_W-1:0] target_i,
  output logic             valid_o
);
  logic [TGT_W-1:0] win_q;
  logic [TGT_W:0]   win_nxt;

  assign win_nxt = {1'b0, win_q} + {{TGT_W{1'b0}}, edge_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      valid_o <= 1'b0;
    end else if (clr_i) begin
      win_q   <= '0;
      valid_o <= 1'b0;
    end else if (run_i) begin
      win_q <= win_nxt[TGT_W-1:0];
      if (win_nxt >= {1'b0, target_i}) valid_o <= 1'b1;
    end
  end

  assert_valid_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !clr_i |=> valid_o);
  assert_valid_needs_run_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && !run_i |=> !valid_o);
  assert_window_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !clr_i |=> $stable(win_q));
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !valid_o && win_q == '0);
endmodule

// File: rtl/fm_refcnt.sv
module fm_refcnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_o <= '0;
    else if (clr_i)                     cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end

  assert_no_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o == CNT_MAX && !clr_i |=> cnt_o == CNT_MAX);
  assert_no_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o != '0 && !clr_i |=> cnt_o != '0);
endmodule

// File: rtl/fm_regs.sv
module fm_regs
  import fm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  input  logic              valid_i,
  input  logic [CNT_W-1:0]  result_i,
  output logic              en_o,
  output logic              en_nxt_o,
  output logic [TGT_W-1:0]  target_o,
  output logic              frck_o
);
  logic ctrl_wr, mon_wr;
  logic [REG_DW-1:0] res_ext;

  assign ctrl_wr  = we_i && addr_i == OFS_CTRL;
  assign mon_wr   = we_i && addr_i == OFS_MON;
  assign en_nxt_o = ctrl_wr ? wdata_i[EN_BIT] : en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      target_o <= '0;
      frck_o   <= 1'b0;
    end else begin
      en_o <= en_nxt_o;
      if (ctrl_wr) target_o <= wdata_i[TGT_W-1:0];
      if (mon_wr)  frck_o   <= wdata_i[FRCK_BIT];
    end
  end

  generate
    if (CNT_W < REG_DW) begin : g_pad
      assign res_ext = {{(REG_DW-CNT_W){1'b0}}, result_i};
    end else begin : g_full
      assign res_ext = result_i[REG_DW-1:0];
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: begin
        rdata_o[TGT_W-1:0] = target_o;
        rdata_o[EN_BIT]    = en_o;
      end
      OFS_MON: begin
        rdata_o[FRCK_BIT]  = frck_o;
        rdata_o[VALID_BIT] = valid_i;
      end
      OFS_RES: rdata_o = valid_i ? res_ext : '0;
      default: rdata_o = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[REG_DW-1:EN_BIT+1]};

  assert_res_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == OFS_RES && !valid_i |-> rdata_o == '0);
  assert_gate_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mon_wr |=> $stable(frck_o));
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import fm_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  reg_addr_i,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        meas_clk_i,
  output logic        frck_en_o
);
  logic             en_q, en_nxt, valid, edge_det, clr, run;
  logic [TGT_W-1:0] target;
  logic [CNT_W-1:0] ref_cnt;

  assign clr = ~en_nxt;
  assign run = en_q & frck_en_o & ~valid;

  fm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .addr_i   (reg_addr_i),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .valid_i  (valid),
    .result_i (ref_cnt),
    .en_o     (en_q),
    .en_nxt_o (en_nxt),
    .target_o (target),
    .frck_o   (frck_en_o)
  );

  fm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .async_i (meas_clk_i & frck_en_o),
    .edge_o  (edge_det)
  );

  fm_window #(.TGT_W(TGT_W)) u_win (
    .clk_i, .rst_ni,
    .clr_i    (clr),
    .run_i    (run),
    .edge_i   (edge_det),
    .target_i (target),
    .valid_o  (valid)
  );

  fm_refcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i (clr),
    .inc_i (run),
    .cnt_o (ref_cnt)
  );

  assert_off_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == OFS_CTRL && !reg_wdata_i[EN_BIT] |=> !valid && ref_cnt == '0);
  assert_gate_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frck_en_o && en_nxt |=> $stable(ref_cnt));
endmodule

// File: tb/freq_meter_test.sv
module freq_meter_test;
  localparam int CW = 12;
  localparam int CMAX = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        meas = 1'b0;
  logic        frck;

  int n_chk = 0, n_bad = 0;
  int per = 8;
  int ph = 0;
  bit meas_on = 1'b0;
  bit done = 1'b0;
  int cyc = 0;

  always #5 clk = ~clk;

  freq_meter #(.CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .meas_clk_i(meas), .frck_en_o(frck)
  );

  always @(negedge clk) begin
    if (!meas_on) begin
      meas <= 1'b0; ph <= 0;
    end else begin
      meas <= (ph < per / 2);
      ph   <= (ph + 1 >= per) ? 0 : ph + 1;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input longint act, input longint lo, input longint hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); we = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_valid(input int limit, output bit ok);
    logic [31:0] m;
    ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      rd(8'h10, m);
      if (m[0]) begin ok = 1'b1; break; end
    end
  endtask

  function automatic longint lo_bound(input int t, input int p);
    return (t - 1) * p + 1;
  endfunction

  function automatic longint hi_bound(input int t, input int p);
    return t * p;
  endfunction

  task automatic measure(input int t, input int p, input string req);
    bit ok;
    logic [31:0] r;
    meas_on = 1'b0; per = p;
    repeat (3) @(negedge clk);
    meas_on = 1'b1;
    repeat (20) @(negedge clk);
    wr(8'h00, 32'h0100_0000 | t);
    wait_valid(t * p + 50, ok);
    chk({req, " valid"}, ok, 1);
    rd(8'h0c, r);
    chk_rng({req, " result"}, r, lo_bound(t, p), hi_bound(t, p));
    wr(8'h00, 32'h0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2;
    bit ok;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1
    rd(8'h00, r); chk("R1 ctrl", r, 0);
    rd(8'h10, r); chk("R1 mon", r, 0);
    rd(8'h0c, r); chk("R1 result", r, 0);
    chk("R1 gate", frck, 0);

    // R2
    wr(8'h00, 32'hFE12_3456);
    rd(8'h00, r); chk("R2 readback off", r, 32'h0012_3456);
    meas_on = 1'b1; per = 4;
    wr(8'h00, 32'h01AB_CDEF);
    rd(8'h00, r); chk("R2 readback on", r, 32'h01AB_CDEF);
    // R9: gate clear, nothing counts
    repeat (200) @(negedge clk);
    rd(8'h10, r); chk("R9 no valid gate off", r[0], 0);
    wr(8'h00, 32'h0);

    // R3, R10
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, r); chk("R3 mon readback", r, 32'h100);
    chk("R3 gate out", frck, 1);
    wr(8'h0c, 32'hDEAD_BEEF);
    rd(8'h0c, r); chk("R10 result write ignored", r, 0);
    rd(8'h04, r); chk("R10 unmapped", r, 0);

    // R4, R5 directed
    measure(16, 8, "R5 P8 T16");
    meas_on = 1'b1;
    wr(8'h00, 32'h0100_0010);
    wait_valid(400, ok);
    rd(8'h0c, r);
    repeat (100) @(negedge clk);
    rd(8'h10, r2); chk("R4 sticky valid", r2[0], 1);
    rd(8'h0c, r2); chk("R4 result held", r2, r);
    // R8
    wr(8'h00, 32'h0000_0010);
    rd(8'h10, r); chk("R8 valid cleared", r[0], 0);
    rd(8'h0c, r); chk("R8 result cleared", r, 0);

    // R5 random
    for (int k = 0; k < 8; k++) begin
      int t, p;
      p = 2 + int'($urandom % 10);
      t = 1 + int'($urandom % 40);
      measure(t, p, "R5 random");
    end
    measure(1, 5, "R5 T1");

    // R7: typical 1024-edge window overflows the 12-bit counter
    meas_on = 1'b0; per = 8;
    repeat (3) @(negedge clk);
    meas_on = 1'b1;
    repeat (20) @(negedge clk);
    wr(8'h00, 32'h0100_0400);
    wait_valid(9000, ok);
    chk("R7 valid", ok, 1);
    rd(8'h0c, r); chk("R7 saturated", r, CMAX);
    wr(8'h00, 32'h0);

    // R6: no toggling
    meas_on = 1'b0;
    wr(8'h00, 32'h0100_0004);
    repeat (300) @(negedge clk);
    rd(8'h10, r); chk("R6 no valid", r[0], 0);
    rd(8'h0c, r); chk("R6 result zero", r, 0);
    wr(8'h00, 32'h0);

    // R11
    wr(8'h00, 32'h0100_0000);
    repeat (3) @(negedge clk);
    rd(8'h10, r); chk("R11 valid", r[0], 1);
    rd(8'h0c, r); chk("R11 result", r, 1);
    wr(8'h00, 32'h0);

    // R9: gate off mid-window freezes, resumes after
    per = 8; meas_on = 1'b1;
    repeat (20) @(negedge clk);
    wr(8'h00, 32'h0100_0014);
    repeat (40) @(negedge clk);
    wr(8'h10, 32'h0);
    repeat (300) @(negedge clk);
    rd(8'h10, r); chk("R9 frozen no valid", r[0], 0);
    wr(8'h10, 32'h100);
    wait_valid(400, ok);
    chk("R9 resumed valid", ok, 1);
    wr(8'h00, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule